// File: doc/BRIEF.md
# Per-Context Pending Priority Selector

This block serves one interrupt target context. Every cycle it looks at the pending and claimed flags and the latched priority of every source slot. It also compares each priority against the context's threshold. From the qualifying sources it picks one and presents that source's identifier on a registered output. An identifier of 0 means nothing is available.

The same register stage drives the interrupt request line toward the hart. Two contexts share one hart: context k feeds hart k/2. That wiring sits outside this block.

The claim logic next to this block reads the selected identifier. The register decode and the source gateways, which update pending state, live elsewhere. The selection is a balanced binary comparison tree, so the latency is one cycle for any number of slots.

Top module: `pri_sel`

## Requirements
- R1: While the synchronous active-high reset is applied, and on the first cycle after it, the selected ID is 0 and the request line is low.
- R2: Slot 0 is never selected, even when it is pending and has the highest priority.
- R3: A source qualifies only when its pending bit is 1 and its claimed bit is 0.
- R4: Among qualifying sources, the one with the numerically largest priority value is selected.
- R5: When qualifying sources share the largest priority, the one with the smallest ID is selected.
- R6: Sources with an ID equal to or above the parameter SRC_COUNT are never selected, whatever their inputs.
- R7: A source qualifies only when its priority is strictly greater than the threshold input. A priority of 0 therefore never qualifies.
- R8: The request output is 1 exactly when the selected ID is nonzero.
- R9: The outputs after a rising edge reflect the inputs present at that edge. Inputs that change every cycle produce a matching result every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pend_i | input | SLOTS | Pending flag per source slot |
| claimed_i | input | SLOTS | Claimed-in-service flag per source slot |
| prio_i | input | SLOTS*PW | Latched priority per slot; slot k at bits k*PW +: PW |
| thresh_i | input | PW | Context priority threshold |
| sel_id_o | output | $clog2(SLOTS) | Selected source ID, 0 for none |
| irq_o | output | 1 | Interrupt request toward the hart |

## Verification
Three things can act in the same cycle: exclusion of a claimed source, the priority and tie-break decision, and the threshold filter. The hardest case is a claimed source that carries the top priority while unclaimed sources tie just below it. A threshold change can also land in the same cycle as a change to the pending set. The sweep provokes these by drawing priorities from a narrow range, so that ties and threshold boundaries are frequent. It also applies a new vector on every cycle. Each result is judged one cycle later against a linear scan computed in the bench.

// File: rtl/pri_sel_pkg.sv
package pri_sel_pkg;
  localparam int MAX_PW = 8;
  typedef logic [MAX_PW-1:0] prio_t;

  // Right-hand entry replaces left only when strictly better; left holds smaller IDs.
  function automatic logic right_wins(input logic lv, input prio_t lp,
                                      input logic rv, input prio_t rp);
    return rv && (!lv || (rp > lp));
  endfunction
endpackage

// File: rtl/pri_sel_qualify.sv
module pri_sel_qualify #(
  parameter int SLOTS     = 32,
  parameter int PW        = 4,
  parameter int SRC_COUNT = 32
) (
  input  logic [SLOTS-1:0]    pend_i,
  input  logic [SLOTS-1:0]    claimed_i,
  input  logic [SLOTS*PW-1:0] prio_i,
  input  logic [PW-1:0]       thresh_i,
  output logic [SLOTS-1:0]    cand_o
);
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    if (k == 0 || k >= SRC_COUNT) begin : g_absent
      assign cand_o[k] = 1'b0;
    end else begin : g_live
      assign cand_o[k] = pend_i[k] & ~claimed_i[k] & (prio_i[k*PW +: PW] > thresh_i);
    end
  end
endmodule

// File: rtl/pri_sel_node.sv
module pri_sel_node #(
  parameter int PW  = 4,
  parameter int IDW = 5
) (
  input  logic           lv,
  input  logic [PW-1:0]  lp,
  input  logic [IDW-1:0] li,
  input  logic           rv,
  input  logic [PW-1:0]  rp,
  input  logic [IDW-1:0] ri,
  output logic           ov,
  output logic [PW-1:0]  op,
  output logic [IDW-1:0] oi
);
  import pri_sel_pkg::*;
  logic take_r;
  assign take_r = right_wins(lv, prio_t'(lp), rv, prio_t'(rp));
  assign ov = lv | rv;
  assign op = take_r ? rp : lp;
  assign oi = take_r ? ri : li;
endmodule

// File: rtl/pri_sel_tree.sv
module pri_sel_tree #(
  parameter int SLOTS = 32,
  parameter int PW    = 4
) (
  input  logic [SLOTS-1:0]         cand_i,
  input  logic [SLOTS*PW-1:0]      prio_i,
  output logic                     win_v_o,
  output logic [$clog2(SLOTS)-1:0] win_id_o
);
  localparam int IDW   = $clog2(SLOTS);
  localparam int NODES = 2*SLOTS - 1;

  // Heap layout: node i has children 2i+1 (lower IDs) and 2i+2.
  logic           nv [NODES];
  logic [PW-1:0]  np [NODES];
  logic [IDW-1:0] ni [NODES];

  for (genvar k = 0; k < SLOTS; k++) begin : g_leaf
    assign nv[SLOTS-1+k] = cand_i[k];
    assign np[SLOTS-1+k] = prio_i[k*PW +: PW];
    assign ni[SLOTS-1+k] = IDW'(k);
  end

  for (genvar i = 0; i < SLOTS-1; i++) begin : g_node
    pri_sel_node #(.PW(PW), .IDW(IDW)) u_node (
      .lv(nv[2*i+1]), .lp(np[2*i+1]), .li(ni[2*i+1]),
      .rv(nv[2*i+2]), .rp(np[2*i+2]), .ri(ni[2*i+2]),
      .ov(nv[i]),     .op(np[i]),     .oi(ni[i])
    );
  end

  assign win_v_o  = nv[0];
  assign win_id_o = ni[0];
endmodule

// File: rtl/pri_sel.sv
module pri_sel #(
  parameter int SLOTS     = 32,
  parameter int PW        = 4,
  parameter int SRC_COUNT = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [SLOTS-1:0]         pend_i,
  input  logic [SLOTS-1:0]         claimed_i,
  input  logic [SLOTS*PW-1:0]      prio_i,
  input  logic [PW-1:0]            thresh_i,
  output logic [$clog2(SLOTS)-1:0] sel_id_o,
  output logic                     irq_o
);
  localparam int IDW = $clog2(SLOTS);

  logic [SLOTS-1:0] cand;
  logic             win_v;
  logic [IDW-1:0]   win_id;

  pri_sel_qualify #(.SLOTS(SLOTS), .PW(PW), .SRC_COUNT(SRC_COUNT)) u_qual (
    .pend_i(pend_i), .claimed_i(claimed_i), .prio_i(prio_i),
    .thresh_i(thresh_i), .cand_o(cand)
  );

  pri_sel_tree #(.SLOTS(SLOTS), .PW(PW)) u_tree (
    .cand_i(cand), .prio_i(prio_i), .win_v_o(win_v), .win_id_o(win_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_id_o <= '0;
      irq_o    <= 1'b0;
    end else begin
      sel_id_o <= win_v ? win_id : '0;
      irq_o    <= win_v;
    end
  end
endmodule

// File: rtl/pri_sel_chk.sv
module pri_sel_chk #(
  parameter int SLOTS     = 32,
  parameter int PW        = 4,
  parameter int SRC_COUNT = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic [SLOTS-1:0]         pend_i,
  input logic [SLOTS-1:0]         claimed_i,
  input logic [SLOTS*PW-1:0]      prio_i,
  input logic [PW-1:0]            thresh_i,
  input logic [$clog2(SLOTS)-1:0] sel_id_o,
  input logic                     irq_o
);
  logic [SLOTS-1:0]    live_q;
  logic [SLOTS*PW-1:0] prio_q;
  logic [PW-1:0]       thr_q;

  always_ff @(posedge clk) begin
    live_q <= pend_i & ~claimed_i;
    prio_q <= prio_i;
    thr_q  <= thresh_i;
  end

  assert_irq_tracks_id_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o == (sel_id_o != '0));

  assert_id_in_range_R6: assert property (@(posedge clk) disable iff (rst)
    int'(sel_id_o) < SRC_COUNT);

  assert_sel_was_live_R3: assert property (@(posedge clk) disable iff (rst)
    (sel_id_o != '0) |-> live_q[sel_id_o]);

  assert_sel_above_thresh_R7: assert property (@(posedge clk) disable iff (rst)
    (sel_id_o != '0) |-> (prio_q[sel_id_o*PW +: PW] > thr_q));
endmodule

bind pri_sel pri_sel_chk #(.SLOTS(SLOTS), .PW(PW), .SRC_COUNT(SRC_COUNT)) u_chk (
  .clk(clk), .rst(rst), .pend_i(pend_i), .claimed_i(claimed_i),
  .prio_i(prio_i), .thresh_i(thresh_i), .sel_id_o(sel_id_o), .irq_o(irq_o)
);

// File: tb/pri_sel_test.sv
`timescale 1ns/1ps
module pri_sel_test;
  localparam int SLOTS = 32;
  localparam int PW    = 4;
  localparam int SRC   = 24;
  localparam int IDW   = $clog2(SLOTS);

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [SLOTS-1:0]    pend = '0;
  logic [SLOTS-1:0]    clmd = '0;
  logic [SLOTS*PW-1:0] prio = '0;
  logic [PW-1:0]       thr  = '0;
  logic [IDW-1:0]      sel_id;
  logic                irq;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pri_sel #(.SLOTS(SLOTS), .PW(PW), .SRC_COUNT(SRC)) uut (
    .clk(clk), .rst(rst), .pend_i(pend), .claimed_i(clmd),
    .prio_i(prio), .thresh_i(thresh_i_w), .sel_id_o(sel_id), .irq_o(irq)
  );
  logic [PW-1:0] thresh_i_w;
  assign thresh_i_w = thr;

  function automatic int ref_best();
    int best = 0;
    int bp = 0;
    for (int i = 1; i < SRC; i++) begin
      int p = int'(prio[i*PW +: PW]);
      if (pend[i] && !clmd[i] && p > int'(thr) && (best == 0 || p > bp)) begin
        best = i;
        bp = p;
      end
    end
    return best;
  endfunction

  task automatic check(input int exp_id, input string tag);
    checks++;
    if (int'(sel_id) != exp_id) begin
      errors++;
      $display("FAIL %s id: actual=%0d expected=%0d", tag, sel_id, exp_id);
    end
    checks++;
    if (irq != (exp_id != 0)) begin
      errors++;
      $display("FAIL R8 (%s) irq: actual=%0b expected=%0b", tag, irq, exp_id != 0);
    end
  endtask

  // Inputs are set at a falling edge; the result is registered at the next rising edge.
  task automatic apply(input string tag);
    int e;
    e = ref_best();
    @(posedge clk);
    @(negedge clk);
    check(e, tag);
  endtask

  task automatic clear_all();
    pend = '0; clmd = '0; prio = '0; thr = '0;
  endtask

  task automatic set_src(input int id, input int p);
    pend[id] = 1'b1;
    prio[id*PW +: PW] = PW'(p);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset holds outputs at zero despite attractive inputs
    pend = '1; prio = '1; thr = '0;
    repeat (3) @(negedge clk);
    check(0, "R1 during reset");
    clear_all();
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(0, "R1 after reset");

    // R2: slot 0 excluded
    clear_all(); set_src(0, 15); apply("R2 slot0 only");
    set_src(1, 1); apply("R2 slot0 vs slot1");

    // R3: claimed excluded
    clear_all(); set_src(5, 9); clmd[5] = 1'b1; apply("R3 claimed");
    clmd[5] = 1'b0; apply("R3 unclaimed");
    set_src(8, 12); clmd[8] = 1'b1; apply("R3 claimed top");
    pend[5] = 1'b0; clmd[5] = 1'b1; apply("R3 claimed without pending");

    // R4: highest priority wins
    clear_all(); set_src(3, 2); set_src(9, 7); apply("R4 higher id higher prio");
    set_src(1, 8); apply("R4 lower id higher prio");

    // R5: tie goes to smallest ID
    clear_all(); set_src(12, 6); set_src(7, 6); set_src(4, 6); apply("R5 three way tie");
    set_src(22, 6); set_src(2, 5); apply("R5 tie with lower loser");

    // R6: IDs at or above SRC_COUNT never chosen
    clear_all(); set_src(25, 15); set_src(20, 1); apply("R6 high slot masked");
    clear_all(); set_src(30, 15); set_src(31, 15); apply("R6 only out-of-range");
    clear_all(); set_src(SRC-1, 3); set_src(SRC, 15); apply("R6 last valid slot");

    // R7: strict threshold, priority 0 never
    clear_all(); thr = 4'd5; set_src(2, 5); set_src(6, 6); apply("R7 above threshold");
    prio[6*PW +: PW] = 4'd5; apply("R7 equal to threshold");
    clear_all(); set_src(3, 0); apply("R7 priority zero");
    thr = 4'd15; set_src(4, 15); apply("R7 max threshold");

    // R9 plus combined sweep: a new vector each cycle, narrow priority range
    for (int n = 0; n < 4000; n++) begin
      int e;
      pend = $urandom();
      clmd = $urandom() & $urandom();
      for (int k = 0; k < SLOTS; k++) prio[k*PW +: PW] = PW'($urandom_range(0, 3));
      thr = PW'($urandom_range(0, 2));
      if (n % 7 == 0) pend = pend & 32'h0000_00F1;
      e = ref_best();
      @(posedge clk);
      @(negedge clk);
      check(e, "R3 R4 R5 R6 R7 R9 sweep");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule